// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four modem handshake lines and reports them to a UART host interface. The four lines are carrier detect, ring indicator, data set ready and clear to send. Each line crosses into the block's clock domain through a short synchronizer. The block then compares the line against its value from one cycle earlier. A detected change latches a sticky flag, and that flag stays set until the CPU finishes reading the status byte.

The 8-bit status byte holds two nibbles. The upper nibble gives the live, synchronized level of each line. The lower nibble gives the change flags. The ring flag reacts only when the ring signal ends, that is, on a high-to-low transition. The other three flags react to a transition in either direction. An interrupt request is raised while any flag is set. The host pulses `rd_done_i` for one cycle at the end of a status read, which clears all flags. A change detected in that same cycle still wins and keeps its flag set.

After reset is released, flag detection stays disarmed until the synchronizer and the previous-value registers hold the live line levels. As a result, levels present at reset do not produce false change flags.

Top module: `modem_status_monitor`

## Requirements
- R1: `lines_i` bit 3 is carrier, bit 2 ring, bit 1 data set ready, bit 0 clear to send. `status_o[7:4]` shows these levels in the same order, and a line change appears there after two rising clock edges.
- R2: Flags `status_o[3]` (carrier), `status_o[1]` (data set ready) and `status_o[0]` (clear to send) are set on either a rising or a falling transition of their line, three rising edges after the input change.
- R3: Flag `status_o[2]` is set only when the ring line falls from 1 to 0, with the same latency. A rising ring transition leaves it at 0.
- R4: A set flag stays set while `rd_done_i` is low, whatever the lines do.
- R5: A one-cycle `rd_done_i` pulse clears all four flags at the next rising edge.
- R6: If a flag's change is detected in the same cycle as `rd_done_i`, that flag ends up set. Flags without a coincident change still clear.
- R7: `irq_o` is high exactly when at least one of `status_o[3:0]` is 1, in the same cycle, with no added delay.
- R8: While reset is asserted, `status_o` and `irq_o` are 0. After release, no flag is set because of line levels that were already present at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lines_i | input | 4 | Asynchronous modem lines: {carrier, ring, data set ready, clear to send} |
| rd_done_i | input | 1 | One-cycle pulse at completion of a status read |
| status_o | output | 8 | {line levels[3:0], change flags[3:0]} |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
The assertions check on every cycle that each flag sets after a detected change and only after one. They also check that a clear without a coincident change drops a flag, and that a flag holds when there is neither a clear nor a change. Other cycle-by-cycle checks are that the flags stay at zero before detection is armed and that the interrupt only falls after a read pulse. Only the bench scenarios can show the end-to-end behaviour at the ports. That includes the latency in edges from a line toggle, the ring flag ignoring a rising ring, and the correct bit positions. It also includes the collision where a new change meets the read-clear pulse, and the absence of flags after reset for every starting pattern of the lines.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int NUM_LINES = 4;
  localparam int CTS_IDX   = 0;
  localparam int DSR_IDX   = 1;
  localparam int RING_IDX  = 2;
  localparam int CARR_IDX  = 3;
  localparam int STATUS_W  = 2 * NUM_LINES;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msd_delta_flag.sv
module msd_delta_flag #(
  parameter bit TRAIL_ONLY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic level_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, flag_q, edge_hit, change;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  if (TRAIL_ONLY) begin : g_trail
    assign edge_hit = prev_q & ~level_i;
  end else begin : g_any
    assign edge_hit = prev_q ^ level_i;
  end

  assign change = arm_i & edge_hit;

  // a change in the clear cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (change) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change |=> flag_o); // R2 R3 R6
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !change) |=> !flag_o); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !change) |=> $stable(flag_o)); // R4
  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(arm_i && level_i != prev_q)); // R2
  if (TRAIL_ONLY) begin : g_ast_trail
    AST_RING_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> $past(prev_q && !level_i)); // R3
  end
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
  import msd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 rd_done_i,
  output logic [STATUS_W-1:0]  status_o,
  output logic                 irq_o
);
  localparam int ARM_W = SYNC_STAGES + 1;

  logic [NUM_LINES-1:0] level;
  logic [NUM_LINES-1:0] flags;
  logic [ARM_W-1:0]     arm_q;
  logic                 armed;

  msd_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lines_i),
    .q_o   (level)
  );

  // hold detection off until synchronizer and previous copies are filled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= '0;
    else         arm_q <= {arm_q[ARM_W-2:0], 1'b1};
  end
  assign armed = arm_q[ARM_W-1];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    msd_delta_flag #(.TRAIL_ONLY(i == RING_IDX)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (armed),
      .level_i(level[i]),
      .clr_i  (rd_done_i),
      .flag_o (flags[i])
    );
  end

  assign status_o = {level, flags};
  assign irq_o    = |flags;

  AST_QUIET_UNTIL_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (status_o[NUM_LINES-1:0] == '0)); // R8
  AST_IRQ_DROP_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(rd_done_i)); // R7
endmodule

// File: tb/modem_status_monitor_test.sv
module modem_status_monitor_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] lines = 4'h0;
  logic       rd_done = 1'b0;
  logic [7:0] status;
  logic       irq;
  int         n_checks = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  modem_status_monitor uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .lines_i  (lines),
    .rd_done_i(rd_done),
    .status_o (status),
    .irq_o    (irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] p);
    tick();
    rst_ni = 1'b0; lines = p; rd_done = 1'b0;
    tick(); tick();
    check({irq, status[6:0]} | {1'b0, status[7], 6'h0}, 8'h00, "R8 status in reset");
    rst_ni = 1'b1;
    repeat (5) tick();
    check(status, {p, 4'h0}, "R1 R8 levels, no flags after reset");
    check({7'h0, irq}, 8'h00, "R8 irq after reset");
  endtask

  task automatic read_clear();
    rd_done = 1'b1; tick(); rd_done = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < 16; p++) begin
      // single-line toggles
      for (int b = 0; b < 4; b++) begin
        logic       old;
        logic [3:0] expf;
        do_reset(p[3:0]);
        old = lines[b];
        lines[b] = ~old;
        tick(); tick();
        check({4'h0, status[7:4]}, {4'h0, lines}, "R1 level after two edges");
        tick();
        expf = (b == 2) ? (old ? 4'b0100 : 4'b0000) : (4'b0001 << b);
        check({4'h0, status[3:0]}, {4'h0, expf}, (b == 2) ? "R3 ring flag" : "R2 delta flag");
        check({7'h0, irq}, {7'h0, |expf}, "R7 irq follows flags");
        lines[b] = old;
        repeat (4) tick();
        expf = (b == 2) ? 4'b0100 : (4'b0001 << b);
        check({4'h0, status[3:0]}, {4'h0, expf}, "R4 sticky flag");
        read_clear();
        check({4'h0, status[3:0]}, 8'h00, "R5 flags cleared by read");
        check({7'h0, irq}, 8'h00, "R7 irq low after clear");
      end
      // all lines at once
      do_reset(p[3:0]);
      lines = ~p[3:0];
      repeat (3) tick();
      check({4'h0, status[3:0]}, {4'h0, 4'b1011 | (p[2] ? 4'b0100 : 4'b0000)}, "R2 R3 all lines toggled");
      read_clear();
      check({4'h0, status[3:0]}, 8'h00, "R5 clear after multi toggle");
    end

    // collision of new change with read clear
    do_reset(4'h0);
    lines = 4'b0011;
    repeat (3) tick();
    check({4'h0, status[3:0]}, 8'h03, "R2 pre-collision flags");
    lines[0] = 1'b0;
    tick(); tick();
    read_clear();
    check({4'h0, status[3:0]}, 8'h01, "R6 change beats clear");
    check({7'h0, irq}, 8'h01, "R7 irq kept by collision");
    read_clear();
    check({4'h0, status[3:0]}, 8'h00, "R5 later clear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule